// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Arbiter

This block decides, once per instruction boundary, which pending interrupt the CPU takes next. It watches an edge-triggered non-maskable pin, a debug-port request, eight external request lines and a parameterizable group of on-chip peripheral request lines. The external lines get 4-bit priorities from a small write-only register port. Each peripheral line brings its own 4-bit priority on an input bus. A priority of 0 disables a line.

The winner is compared with the CPU's current 4-bit mask level and its block bit. The non-maskable source ranks at level 16 and beats everything. The debug source ranks next, under its own acceptance rule. Among the maskable lines, the highest level wins, and the lowest index breaks ties. On acceptance the block sends a one-cycle pulse together with strobes for the CPU: save PC, save status, set block bit, set bank bit, and, for maskable sources only, a mask-level load. It also holds an event code and a vector offset until the next acceptance.

Top module: `intc_arbiter`

## Requirements
- R1: After reset, `acc_pulse` is 0, `evt_code` and `vec_off` are 0, every external line priority is 0 and the non-maskable edge select is rising.
- R2: A request line whose priority is 0 is never accepted, whatever the mask level.
- R3: A maskable line is accepted only when its priority is strictly greater than `cpu_imask` and `cpu_bl` is 0. On acceptance `imask_we` is 1 and `imask_new` equals the accepted priority.
- R4: Among eligible maskable lines, the highest priority wins. On equal priority the lowest index wins, with the external lines 0..7 indexed before the peripheral lines.
- R5: The non-maskable pin sets a pending flag on the selected edge. It is accepted when `cpu_bl` is 0, or regardless of `cpu_bl` when `cpu_sleep` is 1. It wins over all other sources even at mask level 15, uses event code 0x1C0, and leaves `imask_we` at 0.
- R6: A debug request pulse is held pending. It is accepted only when `cpu_imask` is below 15 and `cpu_bl` is 0. It wins over every maskable line, and on acceptance gives event code 0x5E0, vector offset 0x600, `set_bl`=1, `set_rb`=1 and `imask_we`=0.
- R7: Writes with `reg_addr`=0 set the priorities of external lines 0..3, and writes with `reg_addr`=1 set lines 4..7. Line k (mod 4) sits at bits [4k+3:4k]. Writing `reg_addr`=2 sets the edge select from bit 0, where 1 means rising and 0 means falling.
- R8: External line k reports event code 0x200+0x20·k, and peripheral line j reports 0x300+0x20·j. Maskable and non-maskable acceptances use vector offset 0x600. `evt_code` and `vec_off` change only together with `acc_pulse`.
- R9: `acc_pulse` lasts one cycle and is never high two cycles in a row. The save and set strobes are high exactly while it is high.
- R10: Nothing is accepted while `insn_boundary` is 0. A pending source is taken once it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| nmi_pin | input | 1 | Non-maskable request pin |
| dbg_req | input | 1 | Debug-port request pulse |
| ext_req | input | 8 | External request lines (level) |
| per_req | input | 2 | Peripheral request lines (level) |
| per_lvl | input | 8 | Peripheral priorities, 4 bits per line |
| insn_boundary | input | 1 | High between instructions |
| cpu_imask | input | 4 | Current CPU mask level |
| cpu_bl | input | 1 | Current CPU block bit |
| cpu_sleep | input | 1 | CPU in sleep or standby |
| acc_pulse | output | 1 | Acceptance pulse |
| evt_code | output | 12 | Event code of last acceptance |
| vec_off | output | 12 | Vector offset of last acceptance |
| save_pc_we | output | 1 | Save PC strobe |
| save_sr_we | output | 1 | Save status strobe |
| set_bl | output | 1 | Set block bit strobe |
| set_rb | output | 1 | Set bank bit strobe |
| imask_we | output | 1 | Load mask level strobe |
| imask_new | output | 4 | Mask level to load |

## Verification
The hardest situation to reach from the ports is several sources being pending at the same edge, so that the non-maskable, debug and maskable ranking is exercised in one sequence. The bench gets there by holding `insn_boundary` low while it fires the pin edge, pulses the debug request and raises an external line. It then opens the boundary and checks three acceptances in order. Pending flags that outlive a refusal, such as a non-maskable edge blocked by `cpu_bl` and later taken in sleep, or a debug request refused at mask 15 and later taken at 14, are reached in the same way: the pending source is left in place while the CPU inputs change.

// File: rtl/intc_arb_pkg.sv
package intc_arb_pkg;
   localparam int LVL_W = 4;
   localparam int EVT_W = 12;
   localparam logic [EVT_W-1:0] EVT_NMI      = 12'h1C0;
   localparam logic [EVT_W-1:0] EVT_DBG      = 12'h5E0;
   localparam logic [EVT_W-1:0] EVT_EXT_BASE = 12'h200;
   localparam logic [EVT_W-1:0] EVT_PER_BASE = 12'h300;
   localparam logic [EVT_W-1:0] EVT_STEP     = 12'h020;
   typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_DBG, SRC_IRQ} src_e;
endpackage

// File: rtl/intc_arb_regs.sv
module intc_arb_regs #(
   parameter int NUM_EXT = 8,
   parameter int LW      = 4,
   parameter int DW      = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [1:0]            addr,
   input  logic [DW-1:0]         wdata,
   output logic [NUM_EXT*LW-1:0] ext_lvl,
   output logic                  nmi_rise
);
   localparam int PER_REG = DW / LW;
   localparam int NREG    = (NUM_EXT + PER_REG - 1) / PER_REG;
   localparam int CFG_ADR = 2;

   if (NREG > CFG_ADR) begin : g_bad_map
      $error("intc_arb_regs: too many external lines for register map");
   end

   logic [DW-1:0] prio_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) prio_q[r] <= '0;
         nmi_rise <= 1'b1;
      end else if (we) begin
         for (int r = 0; r < NREG; r++)
            if (addr == 2'(r)) prio_q[r] <= wdata;
         if (addr == 2'(CFG_ADR)) nmi_rise <= wdata[0];
      end
   end

   for (genvar k = 0; k < NUM_EXT; k++) begin : g_line
      assign ext_lvl[k*LW +: LW] = prio_q[k / PER_REG][(k % PER_REG)*LW +: LW];
   end
endmodule

// File: rtl/intc_arb_pick.sv
module intc_arb_pick #(
   parameter int N  = 10,
   parameter int LW = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    req,
   input  logic [N*LW-1:0] lvl,
   output logic            found,
   output logic [IW-1:0]   win_idx,
   output logic [LW-1:0]   win_lvl
);
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      // scan downward with >= so the lowest index wins a tie
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i] && (lvl[i*LW +: LW] != '0) && (lvl[i*LW +: LW] >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IW'(i);
            win_lvl = lvl[i*LW +: LW];
         end
      end
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_arb_pkg::*;
#(
   parameter int             NUM_EXT = 8,
   parameter int             NUM_PER = 2,
   parameter logic [11:0]    VEC_GEN = 12'h600,
   parameter logic [11:0]    VEC_DBG = 12'h600
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [1:0]               reg_addr,
   input  logic [15:0]              reg_wdata,
   input  logic                     nmi_pin,
   input  logic                     dbg_req,
   input  logic [NUM_EXT-1:0]       ext_req,
   input  logic [NUM_PER-1:0]       per_req,
   input  logic [NUM_PER*LVL_W-1:0] per_lvl,
   input  logic                     insn_boundary,
   input  logic [LVL_W-1:0]         cpu_imask,
   input  logic                     cpu_bl,
   input  logic                     cpu_sleep,
   output logic                     acc_pulse,
   output logic [EVT_W-1:0]         evt_code,
   output logic [11:0]              vec_off,
   output logic                     save_pc_we,
   output logic                     save_sr_we,
   output logic                     set_bl,
   output logic                     set_rb,
   output logic                     imask_we,
   output logic [LVL_W-1:0]         imask_new
);
   localparam int TOTAL = NUM_EXT + NUM_PER;
   localparam int IW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam logic [LVL_W-1:0] TOP_MASK = '1;

   if (NUM_EXT < 1 || NUM_EXT > 8) begin : g_bad_ext
      $error("intc_arbiter: NUM_EXT must be 1..8");
   end
   if (NUM_PER < 1) begin : g_bad_per
      $error("intc_arbiter: NUM_PER must be at least 1");
   end

   logic [NUM_EXT*LVL_W-1:0] ext_lvl;
   logic                     nmi_rise;
   logic [TOTAL-1:0]         all_req;
   logic [TOTAL*LVL_W-1:0]   all_lvl;
   logic                     found;
   logic [IW-1:0]            win_idx;
   logic [LVL_W-1:0]         win_lvl;

   intc_arb_regs #(.NUM_EXT(NUM_EXT), .LW(LVL_W), .DW(16)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .ext_lvl(ext_lvl), .nmi_rise(nmi_rise)
   );

   assign all_req = {per_req, ext_req};
   assign all_lvl = {per_lvl, ext_lvl};

   intc_arb_pick #(.N(TOTAL), .LW(LVL_W), .IW(IW)) u_pick (
      .req(all_req), .lvl(all_lvl), .found(found),
      .win_idx(win_idx), .win_lvl(win_lvl)
   );

   // non-maskable edge capture and pending flags
   logic nmi_q, nmi_pend, dbg_pend, nmi_edge, acc_q;
   assign nmi_edge = nmi_rise ? (nmi_pin & ~nmi_q) : (~nmi_pin & nmi_q);

   logic   can_take, nmi_ok, dbg_ok, irq_ok;
   src_e   pick_src;
   assign can_take = insn_boundary & ~acc_q;
   assign nmi_ok   = nmi_pend & (~cpu_bl | cpu_sleep);
   assign dbg_ok   = dbg_pend & ~cpu_bl & (cpu_imask != TOP_MASK);
   assign irq_ok   = found & ~cpu_bl & (win_lvl > cpu_imask);

   always_comb begin
      pick_src = SRC_NONE;
      if (can_take) begin
         if (nmi_ok)      pick_src = SRC_NMI;
         else if (dbg_ok) pick_src = SRC_DBG;
         else if (irq_ok) pick_src = SRC_IRQ;
      end
   end

   logic [EVT_W-1:0] irq_evt;
   always_comb begin
      if (int'(win_idx) < NUM_EXT)
         irq_evt = EVT_EXT_BASE + EVT_W'(win_idx) * EVT_STEP;
      else
         irq_evt = EVT_PER_BASE + (EVT_W'(win_idx) - EVT_W'(NUM_EXT)) * EVT_STEP;
   end

   logic [EVT_W-1:0] evt_q;
   logic [11:0]      vec_q;
   logic             imwe_q;
   logic [LVL_W-1:0] imnew_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q    <= 1'b0;
         nmi_pend <= 1'b0;
         dbg_pend <= 1'b0;
         acc_q    <= 1'b0;
         evt_q    <= '0;
         vec_q    <= '0;
         imwe_q   <= 1'b0;
         imnew_q  <= '0;
      end else begin
         nmi_q    <= nmi_pin;
         nmi_pend <= nmi_edge | (nmi_pend & (pick_src != SRC_NMI));
         dbg_pend <= dbg_req  | (dbg_pend & (pick_src != SRC_DBG));
         acc_q    <= (pick_src != SRC_NONE);
         imwe_q   <= (pick_src == SRC_IRQ);
         unique case (pick_src)
            SRC_NMI: begin evt_q <= EVT_NMI; vec_q <= VEC_GEN; end
            SRC_DBG: begin evt_q <= EVT_DBG; vec_q <= VEC_DBG; end
            SRC_IRQ: begin evt_q <= irq_evt; vec_q <= VEC_GEN; imnew_q <= win_lvl; end
            default: ;
         endcase
      end
   end

   assign acc_pulse  = acc_q;
   assign evt_code   = evt_q;
   assign vec_off    = vec_q;
   assign save_pc_we = acc_q;
   assign save_sr_we = acc_q;
   assign set_bl     = acc_q;
   assign set_rb     = acc_q;
   assign imask_we   = imwe_q;
   assign imask_new  = imnew_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pulse |=> !acc_pulse);                                               // R9
   AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pulse |-> $past(insn_boundary));                                     // R10
   AST_MASK_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pulse && imask_we) |-> (imask_new > $past(cpu_imask)) && !$past(cpu_bl)); // R3
   AST_NO_ZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pulse && imask_we) |-> (imask_new != '0));                          // R2
   AST_DBG_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pulse && evt_code == EVT_DBG) |-> ($past(cpu_imask) != TOP_MASK) && !$past(cpu_bl) && !imask_we); // R6
   AST_NMI_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pulse && evt_code == EVT_NMI) |-> ($past(!cpu_bl || cpu_sleep)) && !imask_we); // R5
   AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_pulse |-> $stable(evt_code) && $stable(vec_off));                   // R8
endmodule

// File: tb/test_intc_arbiter.sv
module test_intc_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        nmi_pin = 1'b0, dbg_req = 1'b0;
   logic [7:0]  ext_req = '0;
   logic [1:0]  per_req = '0;
   logic [7:0]  per_lvl = '0;
   logic        insn_boundary = 1'b1;
   logic [3:0]  cpu_imask = '0;
   logic        cpu_bl = 1'b0, cpu_sleep = 1'b0;
   logic        acc_pulse, save_pc_we, save_sr_we, set_bl, set_rb, imask_we;
   logic [11:0] evt_code, vec_off;
   logic [3:0]  imask_new;

   int checks = 0, errors = 0, cyc = 0;
   logic [11:0] c_evt, c_vec;
   logic        c_imwe, c_bl, c_rb;
   logic [3:0]  c_imnew;

   always #5 clk = ~clk;

   intc_arbiter i_intc_arbiter (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .nmi_pin(nmi_pin), .dbg_req(dbg_req),
      .ext_req(ext_req), .per_req(per_req), .per_lvl(per_lvl),
      .insn_boundary(insn_boundary), .cpu_imask(cpu_imask), .cpu_bl(cpu_bl),
      .cpu_sleep(cpu_sleep), .acc_pulse(acc_pulse), .evt_code(evt_code),
      .vec_off(vec_off), .save_pc_we(save_pc_we), .save_sr_we(save_sr_we),
      .set_bl(set_bl), .set_rb(set_rb), .imask_we(imask_we), .imask_new(imask_new)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic wait_acc(input int maxc, output bit got);
      got = 1'b0;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (acc_pulse) begin
            got = 1'b1; c_evt = evt_code; c_vec = vec_off; c_imwe = imask_we;
            c_imnew = imask_new; c_bl = set_bl; c_rb = set_rb;
            break;
         end
      end
   endtask

   task automatic settle();
      ext_req = '0; per_req = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      bit got;
      check("R1 acc after reset", acc_pulse, 0);
      check("R1 evt after reset", evt_code, 0);
      check("R1 vec after reset", vec_off, 0);
      ext_req = 8'hFF; cpu_imask = 0;
      wait_acc(6, got);
      check("R1 priorities reset to zero", got, 0);
      settle();
   endtask

   task automatic t_basic();
      bit got;
      wr(0, 16'h4321); wr(1, 16'h8765);
      ext_req = 8'h01; cpu_imask = 0;
      wait_acc(6, got);
      check("R7 line0 accepted", got, 1);
      check("R8 line0 evt", c_evt, 12'h200);
      check("R8 vec", c_vec, 12'h600);
      check("R3 imask_we", c_imwe, 1);
      check("R3 imask_new", c_imnew, 1);
      settle();
      ext_req = 8'h08; cpu_imask = 4;
      wait_acc(6, got);
      check("R3 equal mask refused", got, 0);
      cpu_imask = 3;
      wait_acc(6, got);
      check("R3 above mask accepted", got, 1);
      check("R8 line3 evt", c_evt, 12'h260);
      check("R7 line3 prio", c_imnew, 4);
      settle();
      cpu_imask = 0; cpu_bl = 1; ext_req = 8'hFF;
      wait_acc(6, got);
      check("R3 blocked by bl", got, 0);
      cpu_bl = 0;
      wait_acc(6, got);
      check("R4 highest wins", c_evt, 12'h2E0);
      check("R7 line7 prio", c_imnew, 8);
      settle();
   endtask

   task automatic t_tie();
      bit got;
      wr(1, 16'h5555);
      ext_req = 8'hF0; cpu_imask = 0;
      wait_acc(6, got);
      check("R4 tie lowest index", c_evt, 12'h280);
      settle();
      per_lvl = 8'h99; wr(1, 16'h9999);
      per_req = 2'b11; ext_req = 8'h80;
      wait_acc(6, got);
      check("R4 ext before peripheral on tie", c_evt, 12'h2E0);
      settle();
      per_req = 2'b11;
      wait_acc(6, got);
      check("R8 peripheral0 evt", c_evt, 12'h300);
      settle();
      per_lvl = 8'hA9; per_req = 2'b11;
      wait_acc(6, got);
      check("R8 peripheral1 evt", c_evt, 12'h320);
      check("R4 peripheral1 prio", c_imnew, 10);
      settle();
      wr(0, 16'h0000); per_lvl = 8'h00;
      ext_req = 8'h0F; per_req = 2'b11; cpu_imask = 0;
      wait_acc(6, got);
      check("R2 zero priority ignored", got, 0);
      check("R8 evt held without accept", evt_code, 12'h320);
      settle();
   endtask

   task automatic t_pulse_boundary();
      bit got;
      insn_boundary = 0; ext_req = 8'h80; cpu_imask = 0;
      wait_acc(6, got);
      check("R10 no accept off boundary", got, 0);
      insn_boundary = 1;
      wait_acc(6, got);
      check("R10 accepted at boundary", got, 1);
      check("R9 set_bl with pulse", c_bl, 1);
      @(negedge clk);
      check("R9 pulse one cycle", acc_pulse, 0);
      check("R9 strobes drop", save_pc_we, 0);
      settle();
   endtask

   task automatic t_nmi();
      bit got;
      cpu_imask = 15; nmi_pin = 1;
      wait_acc(6, got);
      check("R5 nmi at mask 15", got, 1);
      check("R5 nmi evt", c_evt, 12'h1C0);
      check("R5 nmi keeps mask", c_imwe, 0);
      nmi_pin = 0; repeat (2) @(negedge clk);
      cpu_bl = 1; nmi_pin = 1;
      wait_acc(6, got);
      check("R5 nmi blocked by bl", got, 0);
      cpu_sleep = 1;
      wait_acc(6, got);
      check("R5 nmi taken in sleep", got, 1);
      cpu_sleep = 0; cpu_bl = 0;
      wr(2, 16'h0000);
      nmi_pin = 0;
      wait_acc(6, got);
      check("R7 falling edge accepted", got, 1);
      nmi_pin = 1;
      wait_acc(6, got);
      check("R7 rising ignored in falling mode", got, 0);
      wr(2, 16'h0001); nmi_pin = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_dbg();
      bit got;
      wr(1, 16'h3000);
      cpu_imask = 15;
      dbg_req = 1; @(negedge clk); dbg_req = 0;
      wait_acc(6, got);
      check("R6 debug refused at mask 15", got, 0);
      cpu_imask = 14;
      wait_acc(6, got);
      check("R6 debug accepted", got, 1);
      check("R6 debug evt", c_evt, 12'h5E0);
      check("R6 debug vec", c_vec, 12'h600);
      check("R6 set_rb", c_rb, 1);
      check("R6 mask untouched", c_imwe, 0);
      cpu_imask = 0;
      insn_boundary = 0;
      nmi_pin = 1; dbg_req = 1; ext_req = 8'h80;
      @(negedge clk); dbg_req = 0;
      repeat (2) @(negedge clk);
      insn_boundary = 1;
      wait_acc(6, got);
      check("R5 nmi ranks first", c_evt, 12'h1C0);
      wait_acc(6, got);
      check("R6 debug before maskable", c_evt, 12'h5E0);
      wait_acc(6, got);
      check("R4 maskable last", c_evt, 12'h2E0);
      check("R3 line7 prio 3", c_imnew, 3);
      nmi_pin = 0;
      settle();
   endtask

   initial begin
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 50000) begin
            errors++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_tie();
      t_pulse_boundary();
      t_nmi();
      t_dbg();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule